// File: doc/BRIEF.md
# Five-Level Third-Order Delta-Sigma Modulator

This block turns an oversampled, signed 18-bit audio stream into a five-level, noise-shaped code stream for a multi-level DAC. The upstream interpolator presents a new word at eight times the audio sample rate. A one-cycle `sampleValid` pulse captures that word into a hold register. The word stays there (zero-order hold) and is presented to the loop for every modulator update until the next pulse. The modulator advances on an internal update strobe. A divider derives that strobe from the system clock, and the clock-ratio select sets its period: an update every 4 system clocks in the 256x mode (64 times the sample rate) and every 8 system clocks in the 384x mode.

The loop is a chain of three delaying integrators. The quantised output is fed back and subtracted at the input of every integrator. Internal state is kept at eight times the loop scale, so every coefficient is an integer and the first integrator sums exactly the input minus the feedback. Each code k in 0..4 stands for a feedback value of (k-2) times one full-scale step, with STEP = 2^16 input LSBs. Code 2 is mid-scale. A mute input clears the loop, restarts the update divider and forces the mid code.

Top module: `ds5_modulator`

## Requirements
- R1: After reset `codeOut` is 2, and at all times `codeOut` is in the range 0..4.
- R2: With `ratioSel`=0 the loop updates on every 4th clock edge, and with `ratioSel`=1 on every 8th. The count starts at the first edge after reset or mute is released: the k-th update falls on edge k*DIV-1, where edge 0 is the first edge. `codeOut` changes on no other edge, except when mute acts.
- R3: `sampleIn` is captured only on an edge where `sampleValid` is 1. Between captures, changes on `sampleIn` have no effect on `codeOut`.
- R4: While `mute` is 1, `codeOut` is 2 from the next edge on and all integrators are zero. After release with a zero held input, every code is 2.
- R5: On each update, with v the feedback of the current code and x the held input, the integrators a, b, c take the values a+x-v, b+a-6v and c+b-12v, all computed from the values before the update. The new `codeOut` is the quantised value of c before the update.
- R6: The quantiser output is the number of thresholds -12*STEP, -4*STEP, +4*STEP, +12*STEP that c meets or exceeds. Code k maps to a feedback of (k-2)*STEP.
- R7: Integrators saturate at the limits of their signed 24-bit range and never wrap. A sustained positive full-scale input yields code 4 almost always, and a sustained negative full-scale input yields code 0 almost always.
- R8: For a constant input x with |x| <= STEP, the mean of (code-2)*STEP over 2048 updates is within 3% of STEP from x.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ratioSel | input | 1 | Clock-ratio mode: 0 = update every 4 clocks, 1 = every 8 clocks |
| mute | input | 1 | Clears the loop, restarts the divider and forces code 2 |
| sampleValid | input | 1 | One-cycle strobe that captures `sampleIn` (8x sample rate) |
| sampleIn | input | 18 | Signed two's-complement input word |
| codeOut | output | 3 | Five-level code, 0..4, 2 = mid-scale |

## Verification
A step input of exactly one STEP is applied from the cleared state and its first eight codes are compared in both ratio modes. This run separates an error in the recurrence, in the inclusive threshold at +4*STEP, or in the update cadence. A zero input must give a stream that is exactly mid-scale. Constant inputs of +STEP/2, -3*STEP/4, +STEP and -STEP/2 test how closely the mean code tracks the input, which a wrong feedback gain or a wrong level mapping would break. Inputs at positive and negative full scale drive the integrators into saturation, where wrap-around would show up as codes at the wrong end of the range. Two further runs cover the hold register and mute: a change on `sampleIn` without a strobe must leave the code stream untouched, and the loop must come out of mute fully cleared.

// File: rtl/ds5_pkg.sv
`timescale 1ns/1ps
package ds5_pkg;
  localparam int CODE_W = 3;
  localparam int LEVELS = 5;
  localparam int STAGES = 3;

  typedef enum logic [CODE_W-1:0] {
    LVL_NEG2 = 3'd0,
    LVL_NEG1 = 3'd1,
    LVL_MID  = 3'd2,
    LVL_POS1 = 3'd3,
    LVL_POS2 = 3'd4
  } level_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new input word
    logic step;   // advance the loop by one update
    logic clear;  // zero the loop and force mid code
  } ds5_ctl_t;
endpackage

// File: rtl/ds5_ctrl.sv
`timescale 1ns/1ps
module ds5_ctrl
  import ds5_pkg::*;
#(
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     ratioSel,
  input  logic     mute,
  input  logic     sampleValid,
  output ds5_ctl_t ctl
);
  localparam int DIV_MAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
  localparam int CNT_W   = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;
  localparam logic [CNT_W-1:0] LAST_LO = CNT_W'(DIV_LO - 1);
  localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(DIV_HI - 1);

  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] lastPhase;
  logic             atLast;
  logic             pastLast;

  assign lastPhase = ratioSel ? LAST_HI : LAST_LO;
  assign atLast    = (phaseCnt == lastPhase);
  assign pastLast  = (phaseCnt >= lastPhase);

  // divider restarts on mute so the update phase is known after release
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (mute || pastLast) begin
      phaseCnt <= '0;
    end else begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  assign ctl.load  = sampleValid;
  assign ctl.step  = atLast && !mute;
  assign ctl.clear = mute;
endmodule

// File: rtl/ds5_integ.sv
`timescale 1ns/1ps
module ds5_integ #(
  parameter int ACC_W = 24
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clear,
  input  logic                    step,
  input  logic signed [ACC_W-1:0] drive,
  input  logic signed [ACC_W-1:0] fbk,
  output logic signed [ACC_W-1:0] acc
);
  localparam int WIDE_W = ACC_W + 2;
  localparam logic signed [WIDE_W-1:0] WIDE_HI = {3'b000, {(ACC_W-1){1'b1}}};
  localparam logic signed [WIDE_W-1:0] WIDE_LO = {3'b111, {(ACC_W-1){1'b0}}};

  logic signed [WIDE_W-1:0] accX;
  logic signed [WIDE_W-1:0] driveX;
  logic signed [WIDE_W-1:0] fbkX;
  logic signed [WIDE_W-1:0] sumWide;
  logic signed [ACC_W-1:0]  sumSat;

  assign accX    = {{2{acc[ACC_W-1]}}, acc};
  assign driveX  = {{2{drive[ACC_W-1]}}, drive};
  assign fbkX    = {{2{fbk[ACC_W-1]}}, fbk};
  assign sumWide = accX + driveX - fbkX;

  always_comb begin
    if (sumWide > WIDE_HI) begin
      sumSat = WIDE_HI[ACC_W-1:0];
    end else if (sumWide < WIDE_LO) begin
      sumSat = WIDE_LO[ACC_W-1:0];
    end else begin
      sumSat = sumWide[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      acc <= '0;
    end else if (step) begin
      acc <= sumSat;
    end
  end
endmodule

// File: rtl/ds5_quant.sv
`timescale 1ns/1ps
module ds5_quant
  import ds5_pkg::*;
#(
  parameter int ACC_W      = 24,
  parameter int STEP_SHIFT = 16
) (
  input  logic signed [ACC_W-1:0] loopVal,
  output logic [CODE_W-1:0]       level
);
  localparam int NTH = LEVELS - 1;

  logic [NTH-1:0] above;

  // thresholds halfway between feedback levels, in the x8 state scale
  for (genvar k = 0; k < NTH; k++) begin : g_th
    localparam longint TH_L = (longint'(8 * k) - longint'(4 * (LEVELS - 2)))
                              * (longint'(1) << STEP_SHIFT);
    localparam logic signed [ACC_W-1:0] TH = ACC_W'(TH_L);
    assign above[k] = (loopVal >= TH);
  end

  assign level = CODE_W'($countones(above));
endmodule

// File: rtl/ds5_datapath.sv
`timescale 1ns/1ps
module ds5_datapath
  import ds5_pkg::*;
#(
  parameter int IN_W       = 18,
  parameter int STEP_SHIFT = 16,
  parameter int ACC_W      = 24
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ds5_ctl_t                ctl,
  input  logic [IN_W-1:0]         sampleIn,
  output logic [IN_W-1:0]         heldSample,
  output logic signed [ACC_W-1:0] integState [STAGES],
  output logic [CODE_W-1:0]       codeOut
);
  localparam logic signed [ACC_W-1:0] STEP_V = ACC_W'(longint'(1) << STEP_SHIFT);
  localparam int GAIN [STAGES] = '{1, 6, 12};

  logic signed [ACC_W-1:0] sampleExt;
  logic signed [ACC_W-1:0] fbkVal;
  logic signed [ACC_W-1:0] stageDrive [STAGES];
  logic signed [ACC_W-1:0] stageFbk   [STAGES];
  logic [CODE_W-1:0]       levelNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldSample <= '0;
    end else if (ctl.load) begin
      heldSample <= sampleIn;
    end
  end

  assign sampleExt = ACC_W'($signed(heldSample));

  ds5_quant #(
    .ACC_W     (ACC_W),
    .STEP_SHIFT(STEP_SHIFT)
  ) u_quant (
    .loopVal(integState[STAGES-1]),
    .level  (levelNow)
  );

  always_comb begin
    case (levelNow)
      LVL_NEG2: fbkVal = -(STEP_V <<< 1);
      LVL_NEG1: fbkVal = -STEP_V;
      LVL_POS1: fbkVal = STEP_V;
      LVL_POS2: fbkVal = STEP_V <<< 1;
      default:  fbkVal = '0;
    endcase
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    localparam logic signed [ACC_W-1:0] GAIN_V = ACC_W'(GAIN[g]);
    if (g == 0) begin : g_head
      assign stageDrive[g] = sampleExt;
    end else begin : g_chain
      assign stageDrive[g] = integState[g-1];
    end
    assign stageFbk[g] = fbkVal * GAIN_V;

    ds5_integ #(
      .ACC_W(ACC_W)
    ) u_integ (
      .clk  (clk),
      .rstN (rstN),
      .clear(ctl.clear),
      .step (ctl.step),
      .drive(stageDrive[g]),
      .fbk  (stageFbk[g]),
      .acc  (integState[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clear) begin
      codeOut <= LVL_MID;
    end else if (ctl.step) begin
      codeOut <= levelNow;
    end
  end
endmodule

// File: rtl/ds5_modulator.sv
`timescale 1ns/1ps
module ds5_modulator
  import ds5_pkg::*;
#(
  parameter int IN_W       = 18,
  parameter int STEP_SHIFT = 16,
  parameter int GUARD_W    = 6,
  parameter int DIV_LO     = 4,
  parameter int DIV_HI     = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ratioSel,
  input  logic            mute,
  input  logic            sampleValid,
  input  logic [IN_W-1:0] sampleIn,
  output logic [2:0]      codeOut
);
  localparam int ACC_W = IN_W + GUARD_W;

  ds5_ctl_t                ctl;
  logic [IN_W-1:0]         heldSample;
  logic signed [ACC_W-1:0] integState [STAGES];

  ds5_ctrl #(
    .DIV_LO(DIV_LO),
    .DIV_HI(DIV_HI)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ratioSel   (ratioSel),
    .mute       (mute),
    .sampleValid(sampleValid),
    .ctl        (ctl)
  );

  ds5_datapath #(
    .IN_W      (IN_W),
    .STEP_SHIFT(STEP_SHIFT),
    .ACC_W     (ACC_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .sampleIn  (sampleIn),
    .heldSample(heldSample),
    .integState(integState),
    .codeOut   (codeOut)
  );
endmodule

// File: rtl/ds5_modulator_chk.sv
`timescale 1ns/1ps
module ds5_modulator_chk #(
  parameter int IN_W  = 18,
  parameter int ACC_W = 24
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    mute,
  input logic                    sampleValid,
  input logic                    stepPulse,
  input logic [2:0]              codeOut,
  input logic [IN_W-1:0]         heldSample,
  input logic signed [ACC_W-1:0] acc0,
  input logic signed [ACC_W-1:0] acc1,
  input logic signed [ACC_W-1:0] acc2
);
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  // R1
  code_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    codeOut <= 3'd4);

  // R2
  step_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepPulse |=> !stepPulse);

  // R2
  code_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stepPulse && !mute) |=> $stable(codeOut));

  // R3
  sample_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(heldSample));

  // R4
  mute_mid_chk: assert property (@(posedge clk) disable iff (!rstN)
    mute |=> codeOut == 3'd2);

  // R4
  mute_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    mute |=> (acc0 == '0 && acc1 == '0 && acc2 == '0));

  // R7
  no_wrap_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acc0 == ACC_MAX) |=> !acc0[ACC_W-1]);

  // R7
  no_wrap_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acc2 == ACC_MIN) |=> (acc2[ACC_W-1] || acc2 == '0));
endmodule

bind ds5_modulator ds5_modulator_chk #(
  .IN_W (IN_W),
  .ACC_W(ACC_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .mute       (mute),
  .sampleValid(sampleValid),
  .stepPulse  (ctl.step),
  .codeOut    (codeOut),
  .heldSample (heldSample),
  .acc0       (integState[0]),
  .acc1       (integState[1]),
  .acc2       (integState[2])
);

// File: tb/test_ds5_modulator.sv
`timescale 1ns/1ps
module test_ds5_modulator;
  localparam int     IN_W = 18;
  localparam longint STEP = 65536;
  localparam int     DIV0 = 4;
  localparam int     DIV1 = 8;
  localparam int     NAVG = 2048;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            ratioSel = 1'b0;
  logic            mute = 1'b0;
  logic            sampleValid = 1'b0;
  logic [IN_W-1:0] sampleIn = '0;
  logic [2:0]      codeOut;

  int nChecked = 0;
  int nFailed  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  ds5_modulator i_ds5_modulator (
    .clk        (clk),
    .rstN       (rstN),
    .ratioSel   (ratioSel),
    .mute       (mute),
    .sampleValid(sampleValid),
    .sampleIn   (sampleIn),
    .codeOut    (codeOut)
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint lo, input longint hi);
    nChecked++;
    if (act < lo || act > hi) begin
      nFailed++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  // mute, load x, select mode, then release; returns at the negedge before edge 0
  task automatic restart(input longint x, input bit mode);
    @(negedge clk);
    mute = 1'b1;
    ratioSel = mode;
    sampleIn = IN_W'(x);
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    @(negedge clk);
    check("R4", "code while muted", longint'(codeOut), 2, 2);
    mute = 1'b0;
  endtask

  task automatic runSteps(input int n, input int div, output longint sum, output int offMid);
    sum = 0;
    offMid = 0;
    for (int s = 0; s < n; s++) begin
      repeat (div) @(posedge clk);
      @(negedge clk);
      sum += longint'(codeOut) - 2;
      if (codeOut != 3'd2) offMid++;
    end
  endtask

  task automatic testReset();
    check("R1", "code after reset", longint'(codeOut), 2, 2);
  endtask

  task automatic testStartSeq(input bit mode);
    int div;
    int expCode [8] = '{2, 2, 2, 2, 3, 2, 2, 3};
    div = mode ? DIV1 : DIV0;
    restart(STEP, mode);
    for (int e = 0; e < 8 * div; e++) begin
      @(posedge clk);
      @(negedge clk);
      if ((e + 1) % div == 0) begin
        int k;
        k = (e + 1) / div;
        if (k == 5)
          check("R6", "code at inclusive +4 STEP threshold", longint'(codeOut), 3, 3);
        else
          check("R5", "step response code", longint'(codeOut), expCode[k-1], expCode[k-1]);
      end else if (e + 1 == 5 * div - 1) begin
        check("R2", "code one edge before 5th update", longint'(codeOut), 2, 2);
      end
    end
  endtask

  task automatic testMean(input longint x, input bit mode);
    longint sum;
    int     offMid;
    longint err;
    longint tol;
    restart(x, mode);
    runSteps(NAVG, mode ? DIV1 : DIV0, sum, offMid);
    err = sum * STEP - x * NAVG;
    tol = (NAVG * STEP * 3) / 100;
    check("R8", "mean tracking error", err, -tol, tol);
    if (x == 0) check("R8", "codes off mid for zero input", longint'(offMid), 0, 0);
  endtask

  task automatic testHold();
    longint sum;
    int     offMid;
    restart(0, 1'b0);
    sampleIn = IN_W'(STEP);
    runSteps(256, DIV0, sum, offMid);
    check("R3", "codes off mid without strobe", longint'(offMid), 0, 0);
    @(negedge clk);
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    // divider phase is lost here; count deviations over whole clocks
    offMid = 0;
    for (int c = 0; c < 1200; c++) begin
      @(negedge clk);
      if (codeOut != 3'd2) offMid++;
    end
    check("R3", "clocks off mid after strobe", longint'(offMid), 1, 1200);
  endtask

  task automatic testMute();
    longint sum;
    int     offMid;
    restart(STEP / 2, 1'b0);
    runSteps(100, DIV0, sum, offMid);
    @(negedge clk);
    mute = 1'b1;
    @(negedge clk);
    check("R4", "code one edge after mute", longint'(codeOut), 2, 2);
    offMid = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (codeOut != 3'd2) offMid++;
    end
    check("R4", "clocks off mid during mute", longint'(offMid), 0, 0);
    restart(0, 1'b0);
    runSteps(200, DIV0, sum, offMid);
    check("R4", "codes off mid after release", longint'(offMid), 0, 0);
  endtask

  task automatic testSat();
    longint sum;
    int     offMid;
    restart(131071, 1'b0);
    runSteps(NAVG, DIV0, sum, offMid);
    check("R7", "10x code offset sum at +full scale", sum * 10, 19 * NAVG, 20 * NAVG);
    restart(-131072, 1'b0);
    runSteps(NAVG, DIV0, sum, offMid);
    check("R7", "10x code offset sum at -full scale", sum * 10, -20 * NAVG, -19 * NAVG);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testStartSeq(1'b0);
    testStartSeq(1'b1);
    testMean(0, 1'b0);
    testMean(STEP / 2, 1'b0);
    testMean(-(STEP * 3) / 4, 1'b0);
    testMean(STEP, 1'b0);
    testMean(-STEP / 2, 1'b1);
    testHold();
    testMute();
    testSat();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecked, nFailed);
    $finish;
  end

  initial begin
    #(64'd8 * 64'd190000);
    if (!done) begin
      nChecked++;
      nFailed++;
      $display("FAIL watchdog: actual hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecked, nFailed);
      $finish;
    end
  end
endmodule